// File: doc/BRIEF.md
# Filter Bytecode Instruction Decoder

This block splits one 64-bit instruction word of a register-based packet-filter bytecode into the typed fields and flags that an execution stage needs. Each word carries, from the top bit down, a 32-bit signed constant, a 16-bit signed displacement, a source register index, a destination register index and an 8-bit opcode. The low three opcode bits are the class, and they choose how the upper five bits are read. The four memory classes read those bits as an access width and an addressing mode. The four operation classes read them as an operation code and an operand-source select.

One instruction spans two words: it loads a 64-bit constant into a register. The decoder keeps the first word in a register and raises no output for it. It then joins that word with the next accepted word and presents the pair as one decoded instruction. Everything else is combinational from the input word. An instruction that is malformed, uses a reserved mode or names a packet-data mode is still presented, with its illegal flag set, and the execution stage then refuses it.

Top module: `fbc_decoder`

## Requirements
- R1: For a single-word instruction, `out_dst` = bits 11:8, `out_src` = bits 15:12, `out_off` = bits 31:16 sign-extended to 64 bits, and `out_imm` = bits 63:32 sign-extended to 64 bits.
- R2: `out_class` = opcode bits 2:0. `out_is_load` is set for classes 0 and 1, `out_is_store` for classes 2 and 3, `out_is_jump32` for class 6 only and `out_is_alu64` for class 7 only. `out_mem_layout` is set exactly for classes 0 to 3.
- R3: `out_mode` = opcode bits 7:5 and `out_size` = opcode bits 4:3, with size codes 0 = 4 bytes, 1 = 2 bytes, 2 = 1 byte and 3 = 8 bytes. `out_op` = opcode bits 7:4 and `out_src_is_reg` = opcode bit 3, with 1 selecting the source register and 0 the constant.
- R4: An accepted word whose opcode is 0x18 (class 0, mode 0, size 3) while nothing is pending produces `out_valid` = 0 in its cycle and sets `out_pending` from the next cycle.
- R5: The accepted word that follows while pending, whatever its opcode, produces `out_valid` = 1 and `out_is_wide` = 1. It also clears `out_pending`. The outputs carry the first word's fields, with `out_imm` = {second word bits 63:32, first word bits 63:32}.
- R6: While pending, cycles with `in_valid` = 0 leave the pending state and the held word unchanged.
- R7: In classes 0 to 3, modes 1 and 2 (packet access), modes 4, 5 and 7 (reserved), and mode 0 used anywhere other than opcode 0x18 set `out_illegal`. Mode 3 (plain memory) is legal in all four classes.
- R8: Mode 6 (atomic add) is legal only in class 3 with size 0 or 3. Any other use sets `out_illegal`.
- R9: In classes 4 to 7, op codes 14 and 15 set `out_illegal`. In class 6, op codes 0 (unconditional jump), 8 (call) and 9 (return) set `out_illegal` as well.
- R10: A merged 64-bit load whose second word has any nonzero bit in 31:0 sets `out_illegal`.
- R11: `out_valid` is 0 whenever `in_valid` is 0. A synchronous active-high `rst` clears the pending state, so the next accepted word decodes on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Word strobe |
| in_word | input | 64 | Instruction word |
| out_valid | output | 1 | A decoded instruction is presented |
| out_pending | output | 1 | First half of a 64-bit load is held |
| out_class | output | 3 | Instruction class |
| out_mem_layout | output | 1 | Opcode uses the memory layout |
| out_mode | output | 3 | Addressing mode field |
| out_size | output | 2 | Access width code |
| out_op | output | 4 | Operation code |
| out_src_is_reg | output | 1 | Operand comes from the source register |
| out_dst | output | 4 | Destination register index |
| out_src | output | 4 | Source register index |
| out_imm | output | 64 | Sign-extended or merged constant |
| out_off | output | 64 | Sign-extended displacement |
| out_is_load | output | 1 | Load class |
| out_is_store | output | 1 | Store class |
| out_is_alu64 | output | 1 | 64-bit arithmetic class |
| out_is_jump32 | output | 1 | 32-bit compare branch class |
| out_is_wide | output | 1 | Output is a merged two-word load |
| out_illegal | output | 1 | Instruction is not accepted |

## Verification
Two checks fall in the same cycle: completing a two-word merge and judging the legality of the second word's low half. The bench provokes this with second words whose low bits are zero and with second words whose low bits are nonzero. It expects the merged constant and the illegal flag together in that one output cycle. Back-to-back two-word loads, idle gaps inside a pair and a reset while a pair is open test whether the held state is dropped or kept at the right moment.

// File: rtl/fbc_pkg.sv
package fbc_pkg;

    // Word geometry
    localparam int WORD_W  = 64;
    localparam int IMM_W   = 32;
    localparam int OFF_W   = 16;
    localparam int REG_W   = 4;
    localparam int OPC_W   = 8;
    localparam int XLEN    = 64;
    localparam int CLS_W   = 3;
    localparam int MODE_W  = 3;
    localparam int SIZE_W  = 2;
    localparam int OP_W    = 4;

    // Field positions derived from the widths
    localparam int IMM_LSB = WORD_W - IMM_W;
    localparam int OFF_LSB = IMM_LSB - OFF_W;
    localparam int SRC_LSB = OFF_LSB - REG_W;
    localparam int DST_LSB = SRC_LSB - REG_W;
    localparam int SIZE_LSB = CLS_W;
    localparam int MODE_LSB = SIZE_LSB + SIZE_W;
    localparam int SEL_BIT  = CLS_W;
    localparam int OP_LSB   = CLS_W + 1;

    typedef enum logic [CLS_W-1:0] {
        CL_LOAD_IMM  = 3'd0,
        CL_LOAD_REG  = 3'd1,
        CL_STORE_IMM = 3'd2,
        CL_STORE_REG = 3'd3,
        CL_ARITH32   = 3'd4,
        CL_BRANCH    = 3'd5,
        CL_BRANCH32  = 3'd6,
        CL_ARITH64   = 3'd7
    } insn_class_e;

    typedef enum logic [MODE_W-1:0] {
        AM_CONST   = 3'd0,
        AM_PKT_ABS = 3'd1,
        AM_PKT_IND = 3'd2,
        AM_MEMORY  = 3'd3,
        AM_RSV4    = 3'd4,
        AM_RSV5    = 3'd5,
        AM_ATOMIC  = 3'd6,
        AM_RSV7    = 3'd7
    } addr_mode_e;

    typedef enum logic [SIZE_W-1:0] {
        SZ_WORD  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_BYTE  = 2'd2,
        SZ_DWORD = 2'd3
    } acc_size_e;

    localparam logic [OP_W-1:0] OP_LAST_LEGAL = 4'd13;
    localparam logic [OP_W-1:0] OP_GOTO       = 4'd0;
    localparam logic [OP_W-1:0] OP_CALL       = 4'd8;
    localparam logic [OP_W-1:0] OP_RETURN     = 4'd9;

    typedef struct packed {
        insn_class_e      cls;
        logic             mem_layout;
        addr_mode_e       mode;
        acc_size_e        size;
        logic [OP_W-1:0]  op;
        logic             src_is_reg;
        logic [REG_W-1:0] dst;
        logic [REG_W-1:0] src;
        logic [XLEN-1:0]  imm;
        logic [XLEN-1:0]  off;
        logic             is_load;
        logic             is_store;
        logic             is_alu64;
        logic             is_jump32;
        logic             is_wide;
        logic             illegal;
    } decoded_t;

    function automatic logic [XLEN-1:0] sext_imm(input logic [IMM_W-1:0] v);
        return {{(XLEN-IMM_W){v[IMM_W-1]}}, v};
    endfunction

    function automatic logic [XLEN-1:0] sext_off(input logic [OFF_W-1:0] v);
        return {{(XLEN-OFF_W){v[OFF_W-1]}}, v};
    endfunction

    function automatic logic class_is_mem(input insn_class_e c);
        return (c == CL_LOAD_IMM) || (c == CL_LOAD_REG) ||
               (c == CL_STORE_IMM) || (c == CL_STORE_REG);
    endfunction

endpackage

// File: rtl/fbc_legality.sv
module fbc_legality
    import fbc_pkg::*;
(
    input  insn_class_e     cls,
    input  addr_mode_e      mode,
    input  acc_size_e       size,
    input  logic [OP_W-1:0] op,
    output logic            illegal
);

    logic mem_bad;
    logic opn_bad;

    // Memory layout: only plain memory, atomic add on register stores and
    // the wide constant head are accepted.
    always_comb begin
        mem_bad = 1'b1;
        unique case (mode)
            AM_CONST:  mem_bad = !((cls == CL_LOAD_IMM) && (size == SZ_DWORD));
            AM_MEMORY: mem_bad = 1'b0;
            AM_ATOMIC: mem_bad = !((cls == CL_STORE_REG) &&
                                   ((size == SZ_WORD) || (size == SZ_DWORD)));
            default:   mem_bad = 1'b1;
        endcase
    end

    // Operation layout: codes above the last defined one are rejected, and
    // the 32-bit branch class has no goto, call or return.
    always_comb begin
        opn_bad = 1'b0;
        if (op > OP_LAST_LEGAL) begin
            opn_bad = 1'b1;
        end else if (cls == CL_BRANCH32) begin
            opn_bad = (op == OP_GOTO) || (op == OP_CALL) || (op == OP_RETURN);
        end
    end

    assign illegal = class_is_mem(cls) ? mem_bad : opn_bad;

endmodule

// File: rtl/fbc_field_split.sv
module fbc_field_split
    import fbc_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output decoded_t          dec,
    output logic              wide_head
);

    logic [OPC_W-1:0] opc;
    insn_class_e      cls;
    addr_mode_e       mode;
    acc_size_e        size;
    logic [OP_W-1:0]  op;
    logic             bad;

    assign opc  = word[OPC_W-1:0];
    assign cls  = insn_class_e'(opc[CLS_W-1:0]);
    assign mode = addr_mode_e'(opc[MODE_LSB +: MODE_W]);
    assign size = acc_size_e'(opc[SIZE_LSB +: SIZE_W]);
    assign op   = opc[OP_LSB +: OP_W];

    fbc_legality u_legal (
        .cls     (cls),
        .mode    (mode),
        .size    (size),
        .op      (op),
        .illegal (bad)
    );

    assign wide_head = (cls == CL_LOAD_IMM) && (mode == AM_CONST) && (size == SZ_DWORD);

    always_comb begin
        dec            = '0;
        dec.cls        = cls;
        dec.mem_layout = class_is_mem(cls);
        dec.mode       = mode;
        dec.size       = size;
        dec.op         = op;
        dec.src_is_reg = opc[SEL_BIT];
        dec.dst        = word[DST_LSB +: REG_W];
        dec.src        = word[SRC_LSB +: REG_W];
        dec.imm        = sext_imm(word[IMM_LSB +: IMM_W]);
        dec.off        = sext_off(word[OFF_LSB +: OFF_W]);
        dec.is_load    = (cls == CL_LOAD_IMM) || (cls == CL_LOAD_REG);
        dec.is_store   = (cls == CL_STORE_IMM) || (cls == CL_STORE_REG);
        dec.is_alu64   = (cls == CL_ARITH64);
        dec.is_jump32  = (cls == CL_BRANCH32);
        dec.is_wide    = 1'b0;
        dec.illegal    = bad;
    end

endmodule

// File: rtl/fbc_wide_merge.sv
module fbc_wide_merge
    import fbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    input  decoded_t          cur,
    input  logic              wide_head,
    output decoded_t          res,
    output logic              res_valid,
    output logic              pending
);

    decoded_t held;
    logic     pend_q;
    logic     tail_dirty;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            held   <= '0;
        end else if (in_valid) begin
            if (pend_q) begin
                pend_q <= 1'b0;
            end else if (wide_head) begin
                pend_q <= 1'b1;
                held   <= cur;
            end
        end
    end

    assign tail_dirty = (in_word[IMM_LSB-1:0] != '0);

    always_comb begin
        res       = cur;
        res_valid = in_valid && !wide_head;
        if (pend_q) begin
            res         = held;
            res.imm     = {in_word[IMM_LSB +: IMM_W], held.imm[IMM_W-1:0]};
            res.is_wide = 1'b1;
            res.illegal = held.illegal || tail_dirty;
            res_valid   = in_valid;
        end
    end

    assign pending = pend_q;

    p_head_silent_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !pend_q && wide_head) |-> !res_valid);

    p_head_arms_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !pend_q && wide_head) |=> pend_q);

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (pend_q && !in_valid) |=> (pend_q && $stable(held)));

    p_tail_emits_r5: assert property (@(posedge clk) disable iff (rst)
        (pend_q && in_valid) |-> (res_valid && res.is_wide));

    p_tail_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (pend_q && in_valid) |=> !pend_q);

    p_reset_clears_r11: assert property (@(posedge clk)
        rst |=> !pend_q);

endmodule

// File: rtl/fbc_decoder.sv
module fbc_decoder
    import fbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    output logic              out_valid,
    output logic              out_pending,
    output logic [CLS_W-1:0]  out_class,
    output logic              out_mem_layout,
    output logic [MODE_W-1:0] out_mode,
    output logic [SIZE_W-1:0] out_size,
    output logic [OP_W-1:0]   out_op,
    output logic              out_src_is_reg,
    output logic [REG_W-1:0]  out_dst,
    output logic [REG_W-1:0]  out_src,
    output logic [XLEN-1:0]   out_imm,
    output logic [XLEN-1:0]   out_off,
    output logic              out_is_load,
    output logic              out_is_store,
    output logic              out_is_alu64,
    output logic              out_is_jump32,
    output logic              out_is_wide,
    output logic              out_illegal
);

    decoded_t cur_dec;
    decoded_t res_dec;
    logic     head;

    fbc_field_split u_split (
        .word      (in_word),
        .dec       (cur_dec),
        .wide_head (head)
    );

    fbc_wide_merge u_merge (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_word   (in_word),
        .cur       (cur_dec),
        .wide_head (head),
        .res       (res_dec),
        .res_valid (out_valid),
        .pending   (out_pending)
    );

    assign out_class      = res_dec.cls;
    assign out_mem_layout = res_dec.mem_layout;
    assign out_mode       = res_dec.mode;
    assign out_size       = res_dec.size;
    assign out_op         = res_dec.op;
    assign out_src_is_reg = res_dec.src_is_reg;
    assign out_dst        = res_dec.dst;
    assign out_src        = res_dec.src;
    assign out_imm        = res_dec.imm;
    assign out_off        = res_dec.off;
    assign out_is_load    = res_dec.is_load;
    assign out_is_store   = res_dec.is_store;
    assign out_is_alu64   = res_dec.is_alu64;
    assign out_is_jump32  = res_dec.is_jump32;
    assign out_is_wide    = res_dec.is_wide;
    assign out_illegal    = res_dec.illegal;

    p_sext_imm_r1: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_is_wide) |-> (out_imm[XLEN-1:IMM_W] == {(XLEN-IMM_W){in_word[WORD_W-1]}}));

    p_flags_excl_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !(out_is_load && out_is_store) && !(out_is_alu64 && out_mem_layout));

    p_merge_upper_r5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_is_wide) |-> (out_imm[XLEN-1:IMM_W] == in_word[IMM_LSB +: IMM_W]));

    p_reserved_mode_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_mem_layout &&
         (out_mode == AM_RSV4 || out_mode == AM_RSV5 || out_mode == AM_RSV7)) |-> out_illegal);

    p_dirty_tail_r10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_is_wide && (in_word[IMM_LSB-1:0] != '0)) |-> out_illegal);

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> !out_valid);

endmodule

// File: tb/fbc_decoder_bench.sv
`timescale 1ns/1ps
module fbc_decoder_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] in_word = '0;

    logic        out_valid, out_pending, out_mem_layout, out_src_is_reg;
    logic [2:0]  out_class, out_mode;
    logic [1:0]  out_size;
    logic [3:0]  out_op, out_dst, out_src;
    logic [63:0] out_imm, out_off;
    logic        out_is_load, out_is_store, out_is_alu64, out_is_jump32;
    logic        out_is_wide, out_illegal;

    always #2.5 clk = ~clk;

    fbc_decoder u_fbc_decoder (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
        .out_valid(out_valid), .out_pending(out_pending), .out_class(out_class),
        .out_mem_layout(out_mem_layout), .out_mode(out_mode), .out_size(out_size),
        .out_op(out_op), .out_src_is_reg(out_src_is_reg), .out_dst(out_dst),
        .out_src(out_src), .out_imm(out_imm), .out_off(out_off),
        .out_is_load(out_is_load), .out_is_store(out_is_store),
        .out_is_alu64(out_is_alu64), .out_is_jump32(out_is_jump32),
        .out_is_wide(out_is_wide), .out_illegal(out_illegal)
    );

    typedef struct {
        bit          valid;
        bit          pend;
        bit [155:0]  flds;
        string       tag;
    } exp_t;

    exp_t        q[$];
    int          n_checks = 0;
    int          n_fails  = 0;
    bit          m_pend   = 0;
    bit [63:0]   m_head   = '0;

    function automatic bit ref_bad(input bit [7:0] opc);
        bit [2:0] c = opc[2:0];
        bit [2:0] m = opc[7:5];
        bit [1:0] s = opc[4:3];
        bit [3:0] o = opc[7:4];
        if (c <= 3) begin
            if (m == 3) return 0;
            if (m == 0) return !(c == 0 && s == 3);
            if (m == 6) return !(c == 3 && (s == 0 || s == 3));
            return 1;
        end
        if (o == 14 || o == 15) return 1;
        if (c == 6 && (o == 0 || o == 8 || o == 9)) return 1;
        return 0;
    endfunction

    // field order: class, mem, mode, size, op, sel, dst, src, imm, off, ld, st, a64, j32, wide, bad
    function automatic bit [155:0] ref_fields(input bit [63:0] w, input bit [63:0] imm,
                                              input bit wide, input bit bad);
        bit [7:0]  opc = w[7:0];
        bit [2:0]  c   = opc[2:0];
        bit [63:0] off = {{48{w[31]}}, w[31:16]};
        return {c, (c < 4), opc[7:5], opc[4:3], opc[7:4], opc[3], w[11:8], w[15:12],
                imm, off, (c == 0 || c == 1), (c == 2 || c == 3), (c == 7), (c == 6),
                wide, bad};
    endfunction

    task automatic send(input bit v, input bit [63:0] w, input string tag);
        exp_t e;
        @(negedge clk);
        in_valid = v;
        in_word  = w;
        e.valid = 0; e.pend = m_pend; e.flds = '0; e.tag = tag;
        if (v) begin
            if (m_pend) begin
                e.valid = 1;
                e.flds  = ref_fields(m_head, {w[63:32], m_head[63:32]}, 1'b1,
                                     ref_bad(m_head[7:0]) || (w[31:0] != 0));
                m_pend  = 0;
            end else if (w[7:0] == 8'h18) begin
                m_pend = 1;
                m_head = w;
            end else begin
                e.valid = 1;
                e.flds  = ref_fields(w, {{32{w[63]}}, w[63:32]}, 1'b0, ref_bad(w[7:0]));
            end
        end
        q.push_back(e);
    endtask

    function automatic bit [63:0] mk(input bit [31:0] imm, input bit [15:0] off,
                                     input bit [3:0] s, input bit [3:0] d, input bit [7:0] opc);
        return {imm, off, s, d, opc};
    endfunction

    // Monitor: one expected item per driven cycle
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                bit [155:0] act;
                bit bad;
                e = q.pop_front();
                act = {out_class, out_mem_layout, out_mode, out_size, out_op, out_src_is_reg,
                       out_dst, out_src, out_imm, out_off, out_is_load, out_is_store,
                       out_is_alu64, out_is_jump32, out_is_wide, out_illegal};
                n_checks++;
                bad = (out_valid !== e.valid) || (out_pending !== e.pend) ||
                      (e.valid && (act !== e.flds));
                if (bad) begin
                    n_fails++;
                    $display("FAIL %s: valid=%0b/%0b pending=%0b/%0b fields=%h expected %h",
                             e.tag, out_valid, e.valid, out_pending, e.pend,
                             act, e.valid ? e.flds : act);
                end
            end
        end
    end

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        n_checks++;
        if (out_valid !== 1'b0 || out_pending !== 1'b0) begin
            n_fails++;
            $display("FAIL R11 reset state: valid=%0b pending=%0b expected 0 0", out_valid, out_pending);
        end

        // R1: sign extension, register indices
        send(1, mk(32'hFFFF_FF80, 16'h8001, 4'h7, 4'hA, 8'h07), "R1 negative");
        send(1, mk(32'h1234_5678, 16'h7FFE, 4'h3, 4'h5, 8'h0F), "R1 positive");
        // R2: every class
        send(1, mk(32'h0, 16'h0010, 4'h1, 4'h2, 8'h61), "R2 load reg class");
        send(1, mk(32'h55, 16'hFFF0, 4'h0, 4'h3, 8'h62), "R2 store imm class");
        send(1, mk(32'h0, 16'h0004, 4'h6, 4'h1, 8'h63), "R2 store reg class");
        send(1, mk(32'h9, 16'h0, 4'h0, 4'h4, 8'h04), "R2 arith32 class");
        send(1, mk(32'h1, 16'h0003, 4'h2, 4'h4, 8'h15), "R2 branch class");
        send(1, mk(32'h1, 16'hFFFD, 4'h2, 4'h4, 8'h16), "R2 branch32 class");
        // R3: widths and operand select
        send(1, mk(32'h0, 16'h0, 4'h1, 4'h2, 8'h71), "R3 byte width");
        send(1, mk(32'h0, 16'h0, 4'h1, 4'h2, 8'h69), "R3 half width");
        send(1, mk(32'h0, 16'h0, 4'h1, 4'h2, 8'h79), "R3 dword width");
        send(1, mk(32'h0, 16'h0, 4'h8, 4'h9, 8'hBF), "R3 move from register");
        send(1, mk(32'd64, 16'h0, 4'h0, 4'h9, 8'hD4), "R3 op 13");
        // R4/R5: wide load
        send(1, mk(32'h89AB_CDEF, 16'h0, 4'h0, 4'h6, 8'h18), "R4 head");
        send(1, mk(32'h0123_4567, 16'h0, 4'h0, 4'h0, 8'h00), "R5 tail");
        // R6: gaps inside a pair
        send(1, mk(32'hDEAD_BEEF, 16'h0, 4'h0, 4'h2, 8'h18), "R4 head gap");
        send(0, mk(32'hFFFF_FFFF, 16'hFFFF, 4'hF, 4'hF, 8'h18), "R6 idle 1");
        send(0, 64'h0, "R6 idle 2");
        send(0, mk(32'h1, 16'h0, 4'h0, 4'h0, 8'h07), "R6 idle 3");
        send(1, mk(32'hCAFE_F00D, 16'h0, 4'h0, 4'h0, 8'h00), "R5 tail after gap");
        // R7: packet and reserved modes, misused constant mode
        send(1, mk(32'h0, 16'h0, 4'h0, 4'h0, 8'h20), "R7 packet absolute");
        send(1, mk(32'h0, 16'h0, 4'h1, 4'h0, 8'h40), "R7 packet indirect");
        send(1, mk(32'h0, 16'h0, 4'h1, 4'h0, 8'h81), "R7 mode 4");
        send(1, mk(32'h0, 16'h0, 4'h1, 4'h0, 8'hA1), "R7 mode 5");
        send(1, mk(32'h0, 16'h0, 4'h1, 4'h0, 8'hE1), "R7 mode 7");
        send(1, mk(32'h0, 16'h0, 4'h0, 4'h1, 8'h00), "R7 constant mode 4-byte");
        send(1, mk(32'h0, 16'h0, 4'h0, 4'h1, 8'h1A), "R7 constant mode store");
        // R8: atomic add
        send(1, mk(32'h0, 16'h8, 4'h2, 4'h1, 8'hDB), "R8 atomic dword");
        send(1, mk(32'h0, 16'h8, 4'h2, 4'h1, 8'hC3), "R8 atomic word");
        send(1, mk(32'h0, 16'h8, 4'h2, 4'h1, 8'hD3), "R8 atomic byte");
        send(1, mk(32'h0, 16'h8, 4'h2, 4'h1, 8'hC2), "R8 atomic wrong class");
        // R9: operation codes
        send(1, mk(32'h0, 16'h0, 4'h0, 4'h0, 8'hE7), "R9 op 14");
        send(1, mk(32'h0, 16'h0, 4'h0, 4'h0, 8'hF5), "R9 op 15");
        send(1, mk(32'h0, 16'h2, 4'h0, 4'h0, 8'h06), "R9 goto 32-bit");
        send(1, mk(32'h1, 16'h0, 4'h0, 4'h0, 8'h86), "R9 call 32-bit");
        send(1, mk(32'h0, 16'h0, 4'h0, 4'h0, 8'h96), "R9 return 32-bit");
        send(1, mk(32'h0, 16'h2, 4'h0, 4'h0, 8'h05), "R9 goto legal");
        send(1, mk(32'h0, 16'h0, 4'h0, 4'h0, 8'h95), "R9 return legal");
        // R10: dirty tail, back-to-back pairs
        send(1, mk(32'h1111_2222, 16'h0, 4'h0, 4'h3, 8'h18), "R10 head");
        send(1, mk(32'h3333_4444, 16'h0, 4'h0, 4'h0, 8'h01), "R10 dirty tail");
        send(1, mk(32'h8000_0000, 16'h0, 4'h0, 4'h7, 8'h18), "R5 back-to-back head 1");
        send(1, mk(32'hFFFF_FFFF, 16'h0, 4'h0, 4'h0, 8'h00), "R5 back-to-back tail 1");
        send(1, mk(32'h0000_0001, 16'h0, 4'h0, 4'h8, 8'h18), "R5 back-to-back head 2");
        send(1, mk(32'h7FFF_FFFF, 16'h0, 4'h0, 4'h0, 8'h18), "R5 tail with head opcode");
        // R11: idle, reset while pending
        send(0, mk(32'h1, 16'h0, 4'h0, 4'h0, 8'h07), "R11 idle");
        send(1, mk(32'h4444_0000, 16'h0, 4'h0, 4'h2, 8'h18), "R11 head before reset");
        @(negedge clk);
        in_valid = 0;
        rst = 1;
        m_pend = 0;
        @(negedge clk);
        rst = 0;
        #1;
        n_checks++;
        if (out_pending !== 1'b0) begin
            n_fails++;
            $display("FAIL R11 reset while pending: pending=%0b expected 0", out_pending);
        end
        send(1, mk(32'hFFFF_0000, 16'h0, 4'h0, 4'h2, 8'h07), "R11 word after reset");

        // Mixed traffic covering R1/R2/R3/R4/R5/R7/R9
        for (int i = 0; i < 400; i++) begin
            bit [63:0] w;
            w = {$urandom(), $urandom()};
            if (($urandom() % 6) == 0) w[7:0] = 8'h18;
            if (($urandom() % 3) == 0) w[31:8] = '0;
            send(($urandom() % 4) != 0, w, "mixed R1 R2 R3 R5 R7");
        end

        @(negedge clk);
        in_valid = 0;
        wait (q.size() == 0);
        repeat (2) @(negedge clk);
        summary();
        $finish;
    end

endmodule